// File: doc/BRIEF.md
# Pulse Pattern Definition Matcher

Once per machine pulse an upstream source presents a beam pattern: a beam code, a field of legacy pattern bits and a field of local modifier bits. The matcher holds a table of acquisition definitions. Each definition carries its own beam code, a mask of bits that must be set and a mask of bits that must be clear. All active definitions are tested against the same pattern in parallel. The pattern goes out again two cycles later, together with an event field that has one bit per definition that matched.

The low slots are permanent system definitions and always take part in matching. The remaining slots belong to clients and have a lifecycle. A client asks for a slot and gets the lowest free one back, or a busy answer if none is free. It then writes the beam code, the masks, a sample-average count and a measurement count. A GO command arms the slot. An armed slot counts its matches. Once it has produced average × measure matches, it disarms itself and raises a done flag. A release command hands the slot back to the free pool.

Top module: `pdm_matcher`

## Requirements
- R1: The table has NUM_SLOTS (20) slots. Slots 0 to NUM_FIXED-1 (0..4) are fixed: they are always active and ignore commands. Bit i of `out_event` reports a match of slot i.
- R2: Matching uses a combined vector `{pat_mod, pat_legacy}`, so legacy bit k is vector bit k and modifier bit k is vector bit 16+k. A slot matches only if every bit set in its inclusion mask is set in that vector and no bit set in its exclusion mask is set.
- R3: A slot matches only if its beam code equals `pat_beam`.
- R4: A pulse with `pat_valid` high in cycle n produces `out_valid` high in cycle n+2. In that cycle `out_beam`, `out_legacy` and `out_mod` carry the input values. `out_event` is zero whenever `out_valid` is low.
- R5: A configuration write (`cfg_we`) updates one field of slot `cfg_slot`, chosen by `cfg_field`. Code 0 is the beam code (data low bits). Code 1 is the inclusion mask. Code 2 is the exclusion mask. Code 3 holds the counts: average in data[7:0], measure in data[15:8]. Code 4 is a command: bit0 GO, bit1 release.
- R6: A pulse on `rsv_req` gives `rsv_grant` high in the next cycle, with `rsv_slot` set to the lowest free client slot. That slot becomes reserved.
- R7: A client slot that is reserved but not armed never sets its event bit. GO arms a reserved or armed slot only if both counts are nonzero; otherwise GO is ignored.
- R8: An armed slot counts its matches. On the match that reaches average × measure it drops `slot_armed` and raises `slot_done` in the same cycle, and the slot stays reserved. A later GO or release clears `slot_done`.
- R9: A reservation request with no free client slot gives `rsv_busy` (never together with `rsv_grant`) in the next cycle, and no slot changes state.
- R10: Release frees a reserved or armed slot and disarms it. When GO and release are written together, release wins.
- R11: After reset, `out_valid`, `slot_armed`, `slot_done`, `rsv_grant` and `rsv_busy` are low, all client slots are free, and all fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 5 | Target slot of the write |
| cfg_field | input | 3 | Field code of the write |
| cfg_wdata | input | 32 | Write data |
| rsv_req | input | 1 | Client slot reservation request |
| rsv_grant | output | 1 | Reservation granted (one cycle) |
| rsv_busy | output | 1 | No free client slot (one cycle) |
| rsv_slot | output | 5 | Granted slot number |
| pat_valid | input | 1 | Pattern strobe, one per pulse |
| pat_beam | input | 5 | Incoming beam code |
| pat_legacy | input | 16 | Incoming legacy pattern bits |
| pat_mod | input | 16 | Incoming local modifier bits |
| out_valid | output | 1 | Outgoing pattern strobe |
| out_beam | output | 5 | Outgoing beam code |
| out_legacy | output | 16 | Outgoing legacy bits |
| out_mod | output | 16 | Outgoing modifier bits |
| out_event | output | 20 | One event bit per matching slot |
| slot_armed | output | 20 | Per-slot armed state (client slots) |
| slot_done | output | 20 | Per-slot completion flag |

## Verification
The bench builds the block with its default parameters: 20 slots of which 5 are fixed, 5-bit beam codes, two 16-bit pattern fields and 8-bit counts. With these values a short run can reserve every one of the 15 client slots, so the busy path and the lowest-free-slot search are both reached. The 2 × 2 count target completes in four pulses. The masks are placed on both sides of the legacy/modifier boundary, so the bit ordering of the combined vector is exercised.

// File: rtl/pdm_pkg.sv
// Shared types of the pattern definition matcher.
// Assumes: field codes are fixed at the register write port.
package pdm_pkg;
    typedef enum logic [2:0] {
        FLD_BEAM  = 3'd0,
        FLD_INCL  = 3'd1,
        FLD_EXCL  = 3'd2,
        FLD_COUNT = 3'd3,
        FLD_CMD   = 3'd4
    } pdm_field_e;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_RSV   = 2'd1,
        ST_ARMED = 2'd2
    } pdm_state_e;
endpackage

// File: rtl/pdm_alloc.sv
// Client slot allocator: finds the lowest free client slot on a request.
// It hands the choice to the slot table in the same cycle and answers
// with a registered grant or busy one cycle later.
// Assumes: free_vec bits below NUM_FIXED are never set.
module pdm_alloc #(
    parameter int NUM_SLOTS = 20,
    parameter int NUM_FIXED = 5,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [NUM_SLOTS-1:0] free_vec,
    output logic                 take_vld,
    output logic [SLOT_W-1:0]    take_slot,
    output logic                 grant_q,
    output logic                 busy_q,
    output logic [SLOT_W-1:0]    slot_q
);
    logic found;

    // Priority search: the lowest free client index wins.
    always_comb begin
        found     = 1'b0;
        take_slot = '0;
        for (int i = NUM_SLOTS - 1; i >= NUM_FIXED; i--) begin
            if (free_vec[i]) begin
                found     = 1'b1;
                take_slot = SLOT_W'(i);
            end
        end
    end

    assign take_vld = req && found;

    // Registered reply to the requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            busy_q  <= 1'b0;
            slot_q  <= '0;
        end else begin
            grant_q <= take_vld;
            busy_q  <= req && !found;
            if (take_vld) slot_q <= take_slot;
        end
    end
endmodule

// File: rtl/pdm_slot_table.sv
// Definition table: per slot a beam code, inclusion and exclusion masks,
// and, for client slots, counts, lifecycle state and a match counter.
// Assumes: hit is only meaningful while hit_vld is high; 2*CNT_W <= MASK_W.
module pdm_slot_table
    import pdm_pkg::*;
#(
    parameter int NUM_SLOTS = 20,
    parameter int NUM_FIXED = 5,
    parameter int BC_W      = 5,
    parameter int MASK_W    = 32,
    parameter int CNT_W     = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int TGT_W    = 2 * CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [2:0]           cfg_field,
    input  logic [MASK_W-1:0]    cfg_wdata,
    input  logic                 take_vld,
    input  logic [SLOT_W-1:0]    take_slot,
    input  logic                 hit_vld,
    input  logic [NUM_SLOTS-1:0] hit,
    output logic [BC_W-1:0]      beam_q [NUM_SLOTS],
    output logic [MASK_W-1:0]    incl_q [NUM_SLOTS],
    output logic [MASK_W-1:0]    excl_q [NUM_SLOTS],
    output logic [NUM_SLOTS-1:0] active,
    output logic [NUM_SLOTS-1:0] free_vec,
    output logic [NUM_SLOTS-1:0] armed,
    output logic [NUM_SLOTS-1:0] done
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic              sel;
        logic [BC_W-1:0]   beam_r;
        logic [MASK_W-1:0] incl_r;
        logic [MASK_W-1:0] excl_r;

        assign sel       = cfg_we && (cfg_slot == SLOT_W'(i));
        assign beam_q[i] = beam_r;
        assign incl_q[i] = incl_r;
        assign excl_q[i] = excl_r;

        // Field writes common to every slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                beam_r <= '0;
                incl_r <= '0;
                excl_r <= '0;
            end else if (sel) begin
                case (pdm_field_e'(cfg_field))
                    FLD_BEAM: beam_r <= cfg_wdata[BC_W-1:0];
                    FLD_INCL: incl_r <= cfg_wdata;
                    FLD_EXCL: excl_r <= cfg_wdata;
                    default:  ;
                endcase
            end
        end

        if (i < NUM_FIXED) begin : g_fixed
            assign active[i]   = 1'b1;
            assign free_vec[i] = 1'b0;
            assign armed[i]    = 1'b0;
            assign done[i]     = 1'b0;
        end else begin : g_client
            logic [CNT_W-1:0] avg_r;
            logic [CNT_W-1:0] meas_r;
            logic [TGT_W-1:0] target;
            logic [TGT_W-1:0] cnt_r;
            logic             done_r;
            pdm_state_e       st_r;
            logic             cmd_w;
            logic             rel_ok;
            logic             go_ok;
            logic             take_me;

            assign target  = avg_r * meas_r;
            assign cmd_w   = sel && (pdm_field_e'(cfg_field) == FLD_CMD);
            assign rel_ok  = cmd_w && cfg_wdata[1] && (st_r != ST_FREE);
            assign go_ok   = cmd_w && cfg_wdata[0] && (st_r != ST_FREE)
                             && (avg_r != '0) && (meas_r != '0);
            assign take_me = take_vld && (take_slot == SLOT_W'(i));

            // Count fields of the client slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    avg_r  <= '0;
                    meas_r <= '0;
                end else if (sel && (pdm_field_e'(cfg_field) == FLD_COUNT)) begin
                    avg_r  <= cfg_wdata[CNT_W-1:0];
                    meas_r <= cfg_wdata[TGT_W-1:CNT_W];
                end
            end

            // Lifecycle: release, arm, reserve, then match counting.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_r   <= ST_FREE;
                    cnt_r  <= '0;
                    done_r <= 1'b0;
                end else if (rel_ok) begin
                    st_r   <= ST_FREE;
                    cnt_r  <= '0;
                    done_r <= 1'b0;
                end else if (go_ok) begin
                    st_r   <= ST_ARMED;
                    cnt_r  <= '0;
                    done_r <= 1'b0;
                end else if (take_me) begin
                    st_r   <= ST_RSV;
                end else if (st_r == ST_ARMED && hit_vld && hit[i]) begin
                    if (cnt_r + 1'b1 == target) begin
                        st_r   <= ST_RSV;
                        cnt_r  <= '0;
                        done_r <= 1'b1;
                    end else begin
                        cnt_r  <= cnt_r + 1'b1;
                    end
                end
            end

            assign active[i]   = (st_r == ST_ARMED);
            assign armed[i]    = (st_r == ST_ARMED);
            assign free_vec[i] = (st_r == ST_FREE);
            assign done[i]     = done_r;
        end
    end
endmodule

// File: rtl/pdm_match.sv
// Parallel comparator: one match result per slot for a single pattern.
// Purely combinational; the caller registers the result.
// Assumes: the bit vector is {modifier, legacy}.
module pdm_match #(
    parameter int NUM_SLOTS = 20,
    parameter int BC_W      = 5,
    parameter int MASK_W    = 32
) (
    input  logic [BC_W-1:0]      pat_beam,
    input  logic [MASK_W-1:0]    pat_bits,
    input  logic [BC_W-1:0]      beam_q [NUM_SLOTS],
    input  logic [MASK_W-1:0]    incl_q [NUM_SLOTS],
    input  logic [MASK_W-1:0]    excl_q [NUM_SLOTS],
    input  logic [NUM_SLOTS-1:0] active,
    output logic [NUM_SLOTS-1:0] hit
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
        logic beam_eq;
        logic incl_ok;
        logic excl_ok;

        assign beam_eq = (beam_q[i] == pat_beam);
        assign incl_ok = ((pat_bits & incl_q[i]) == incl_q[i]);
        assign excl_ok = ((pat_bits & excl_q[i]) == '0);
        assign hit[i]  = active[i] && beam_eq && incl_ok && excl_ok;
    end
endmodule

// File: rtl/pdm_matcher.sv
// Top of the pulse pattern definition matcher. Stage 1 captures the
// pattern; stage 2 registers the pattern together with the event field
// computed from the table.
// Assumes: at most one pattern strobe per cycle; writes take effect on
// the next pattern evaluated after the write edge.
module pdm_matcher #(
    parameter int NUM_SLOTS = 20,
    parameter int NUM_FIXED = 5,
    parameter int BC_W      = 5,
    parameter int LEGACY_W  = 16,
    parameter int MOD_W     = 16,
    parameter int CNT_W     = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int MASK_W   = LEGACY_W + MOD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [2:0]           cfg_field,
    input  logic [MASK_W-1:0]    cfg_wdata,
    input  logic                 rsv_req,
    output logic                 rsv_grant,
    output logic                 rsv_busy,
    output logic [SLOT_W-1:0]    rsv_slot,
    input  logic                 pat_valid,
    input  logic [BC_W-1:0]      pat_beam,
    input  logic [LEGACY_W-1:0]  pat_legacy,
    input  logic [MOD_W-1:0]     pat_mod,
    output logic                 out_valid,
    output logic [BC_W-1:0]      out_beam,
    output logic [LEGACY_W-1:0]  out_legacy,
    output logic [MOD_W-1:0]     out_mod,
    output logic [NUM_SLOTS-1:0] out_event,
    output logic [NUM_SLOTS-1:0] slot_armed,
    output logic [NUM_SLOTS-1:0] slot_done
);
    logic              s1_vld;
    logic [BC_W-1:0]   s1_beam;
    logic [MASK_W-1:0] s1_bits;

    logic [BC_W-1:0]      beam_q [NUM_SLOTS];
    logic [MASK_W-1:0]    incl_q [NUM_SLOTS];
    logic [MASK_W-1:0]    excl_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] active;
    logic [NUM_SLOTS-1:0] free_vec;
    logic [NUM_SLOTS-1:0] hit;
    logic                 take_vld;
    logic [SLOT_W-1:0]    take_slot;

    // Stage 1: capture the incoming pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_beam <= '0;
            s1_bits <= '0;
        end else begin
            s1_vld <= pat_valid;
            if (pat_valid) begin
                s1_beam <= pat_beam;
                s1_bits <= {pat_mod, pat_legacy};
            end
        end
    end

    pdm_alloc #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_FIXED (NUM_FIXED)
    ) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (rsv_req),
        .free_vec  (free_vec),
        .take_vld  (take_vld),
        .take_slot (take_slot),
        .grant_q   (rsv_grant),
        .busy_q    (rsv_busy),
        .slot_q    (rsv_slot)
    );

    pdm_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_FIXED (NUM_FIXED),
        .BC_W      (BC_W),
        .MASK_W    (MASK_W),
        .CNT_W     (CNT_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_slot  (cfg_slot),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .take_vld  (take_vld),
        .take_slot (take_slot),
        .hit_vld   (s1_vld),
        .hit       (hit),
        .beam_q    (beam_q),
        .incl_q    (incl_q),
        .excl_q    (excl_q),
        .active    (active),
        .free_vec  (free_vec),
        .armed     (slot_armed),
        .done      (slot_done)
    );

    pdm_match #(
        .NUM_SLOTS (NUM_SLOTS),
        .BC_W      (BC_W),
        .MASK_W    (MASK_W)
    ) u_match (
        .pat_beam (s1_beam),
        .pat_bits (s1_bits),
        .beam_q   (beam_q),
        .incl_q   (incl_q),
        .excl_q   (excl_q),
        .active   (active),
        .hit      (hit)
    );

    // Stage 2: register the outgoing pattern and its event field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_beam   <= '0;
            out_legacy <= '0;
            out_mod    <= '0;
            out_event  <= '0;
        end else begin
            out_valid <= s1_vld;
            out_event <= s1_vld ? hit : '0;
            if (s1_vld) begin
                out_beam   <= s1_beam;
                out_legacy <= s1_bits[LEGACY_W-1:0];
                out_mod    <= s1_bits[MASK_W-1:LEGACY_W];
            end
        end
    end
endmodule

// File: rtl/pdm_matcher_chk.sv
// Property checker for pdm_matcher, attached by bind below.
// Assumes: synchronous active-low reset on rst_n.
module pdm_matcher_chk #(
    parameter int NUM_SLOTS = 20,
    parameter int NUM_FIXED = 5,
    parameter int BC_W      = 5,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pat_valid,
    input logic [BC_W-1:0]      pat_beam,
    input logic                 out_valid,
    input logic [BC_W-1:0]      out_beam,
    input logic [NUM_SLOTS-1:0] out_event,
    input logic                 rsv_grant,
    input logic                 rsv_busy,
    input logic [SLOT_W-1:0]    rsv_slot,
    input logic [NUM_SLOTS-1:0] slot_armed,
    input logic [NUM_SLOTS-1:0] slot_done
);
    // R4
    lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |-> ##2 out_valid);
    // R4
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pat_valid, 2));
    // R4
    beam_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_beam == $past(pat_beam, 2));
    // R4
    evt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_event == '0);
    // R9
    rsv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsv_grant && rsv_busy));
    // R6
    rsv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_grant |-> (rsv_slot >= SLOT_W'(NUM_FIXED)) && (rsv_slot < SLOT_W'(NUM_SLOTS)));

    for (genvar i = NUM_FIXED; i < NUM_SLOTS; i++) begin : g_cl
        // R8
        done_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(slot_done[i]) |-> $fell(slot_armed[i]));
        // R7
        client_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_event[i]) |-> $past(slot_armed[i]));
    end
endmodule

bind pdm_matcher pdm_matcher_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_FIXED (NUM_FIXED),
    .BC_W      (BC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pat_valid  (pat_valid),
    .pat_beam   (pat_beam),
    .out_valid  (out_valid),
    .out_beam   (out_beam),
    .out_event  (out_event),
    .rsv_grant  (rsv_grant),
    .rsv_busy   (rsv_busy),
    .rsv_slot   (rsv_slot),
    .slot_armed (slot_armed),
    .slot_done  (slot_done)
);

// File: tb/pdm_matcher_bench.sv
// Scoreboard bench: the driver computes expected event fields from its own
// model of the table and queues them; a monitor pops and compares outputs.
module pdm_matcher_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 20;
    localparam int NF = 5;

    typedef struct {
        logic [NS-1:0] ev;
        logic [4:0]    beam;
        logic [15:0]   leg;
        logic [15:0]   md;
        int            cyc;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [4:0] cfg_slot = '0;
    logic [2:0] cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic rsv_req = 1'b0;
    logic rsv_grant, rsv_busy;
    logic [4:0] rsv_slot;
    logic pat_valid = 1'b0;
    logic [4:0] pat_beam = '0;
    logic [15:0] pat_legacy = '0;
    logic [15:0] pat_mod = '0;
    logic out_valid;
    logic [4:0] out_beam;
    logic [15:0] out_legacy, out_mod;
    logic [NS-1:0] out_event, slot_armed, slot_done;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    item_t sb[$];

    // model: state 0 free, 1 reserved, 2 armed
    logic [4:0]  m_beam [NS];
    logic [31:0] m_incl [NS];
    logic [31:0] m_excl [NS];
    int          m_avg  [NS];
    int          m_meas [NS];
    int          m_cnt  [NS];
    int          m_st   [NS];
    logic [NS-1:0] m_done;

    pdm_matcher u_pdm_matcher (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .rsv_req(rsv_req),
        .rsv_grant(rsv_grant), .rsv_busy(rsv_busy), .rsv_slot(rsv_slot),
        .pat_valid(pat_valid), .pat_beam(pat_beam), .pat_legacy(pat_legacy),
        .pat_mod(pat_mod), .out_valid(out_valid), .out_beam(out_beam),
        .out_legacy(out_legacy), .out_mod(out_mod), .out_event(out_event),
        .slot_armed(slot_armed), .slot_done(slot_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] model_armed();
        logic [NS-1:0] v = '0;
        for (int i = 0; i < NS; i++) v[i] = (m_st[i] == 2);
        return v;
    endfunction

    task automatic cfg(input int slot, input int field, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 5'(slot); cfg_field = 3'(field); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (field)
            0: m_beam[slot] = data[4:0];
            1: m_incl[slot] = data;
            2: m_excl[slot] = data;
            3: begin
                if (slot >= NF) begin
                    m_avg[slot] = int'(data[7:0]);
                    m_meas[slot] = int'(data[15:8]);
                end
            end
            default: begin
                if (slot >= NF && m_st[slot] != 0) begin
                    if (data[1]) begin
                        m_st[slot] = 0; m_cnt[slot] = 0; m_done[slot] = 1'b0;
                    end else if (data[0] && m_avg[slot] != 0 && m_meas[slot] != 0) begin
                        m_st[slot] = 2; m_cnt[slot] = 0; m_done[slot] = 1'b0;
                    end
                end
            end
        endcase
    endtask

    task automatic send(input logic [4:0] b, input logic [15:0] lg, input logic [15:0] md);
        item_t it;
        logic [31:0] bits;
        bits = {md, lg};
        it.ev = '0;
        for (int i = 0; i < NS; i++) begin
            if ((i < NF || m_st[i] == 2) && m_beam[i] == b &&
                (bits & m_incl[i]) == m_incl[i] && (bits & m_excl[i]) == 0) begin
                it.ev[i] = 1'b1;
                if (i >= NF) begin
                    m_cnt[i]++;
                    if (m_cnt[i] == m_avg[i] * m_meas[i]) begin
                        m_st[i] = 1; m_cnt[i] = 0; m_done[i] = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
        it.beam = b; it.leg = lg; it.md = md; it.cyc = cyc + 2;
        sb.push_back(it);
        pat_valid = 1'b1; pat_beam = b; pat_legacy = lg; pat_mod = md;
        @(negedge clk);
        pat_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic reserve();
        int exp_slot = -1;
        for (int i = NS - 1; i >= NF; i--) if (m_st[i] == 0) exp_slot = i;
        @(negedge clk);
        rsv_req = 1'b1;
        @(negedge clk);
        rsv_req = 1'b0;
        if (exp_slot >= 0) begin
            chk("R6 grant", 64'(rsv_grant), 64'd1);
            chk("R6 slot", 64'(rsv_slot), 64'(exp_slot));
            m_st[exp_slot] = 1;
        end else begin
            chk("R9 busy", 64'(rsv_busy), 64'd1);
            chk("R9 no grant", 64'(rsv_grant), 64'd0);
        end
    endtask

    task automatic chk_flags(input string req);
        chk({req, " armed"}, 64'(slot_armed), 64'(model_armed()));
        chk({req, " done"}, 64'(slot_done), 64'(m_done));
    endtask

    // Monitor: pop the scoreboard whenever the design emits a pattern.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    chk("R4 unexpected out_valid", 64'd1, 64'd0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk("R2 R3 event field", 64'(out_event), 64'(it.ev));
                    chk("R4 latency", 64'(cyc), 64'(it.cyc));
                    chk("R4 echo", {27'd0, out_beam, out_mod, out_legacy},
                        {27'd0, it.beam, it.md, it.leg});
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_beam[i] = '0; m_incl[i] = '0; m_excl[i] = '0;
            m_avg[i] = 0; m_meas[i] = 0; m_cnt[i] = 0; m_st[i] = 0;
        end
        m_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 out_valid", 64'(out_valid), 64'd0);
        chk("R11 rsv", {62'd0, rsv_grant, rsv_busy}, 64'd0);
        chk_flags("R11");

        // R1 R5 fixed slots
        cfg(0, 0, 32'd1); cfg(0, 1, 32'h0001_0008); cfg(0, 2, 32'h0000_0100);
        cfg(1, 0, 32'd1); cfg(1, 2, 32'h8000_0000);
        cfg(2, 0, 32'd2);
        cfg(3, 0, 32'd31); cfg(4, 0, 32'd31);
        cfg(2, 4, 32'd1); // R1 command on a fixed slot is ignored
        chk_flags("R1");

        send(5'd1, 16'h0008, 16'h0001); // R2 slots 0,1
        send(5'd1, 16'h0108, 16'h0001); // R2 exclusion on legacy bit 8
        send(5'd1, 16'h0008, 16'h8000); // R2 missing mod bit0, excl mod bit15
        send(5'd1, 16'h0008, 16'h8001); // R2 slot0 only
        send(5'd2, 16'h0008, 16'h0001); // R3 slot2 only
        send(5'd0, 16'hFFFF, 16'hFFFF); // R3 no beam code matches

        // R6 R7 R8 client lifecycle
        reserve();
        cfg(5, 0, 32'd1); cfg(5, 1, 32'h0000_0004); cfg(5, 3, 32'h0000_0202);
        send(5'd1, 16'h0004, 16'h0000); // R7 reserved, not armed
        cfg(5, 4, 32'd1);
        chk_flags("R7 go");
        for (int k = 0; k < 4; k++) send(5'd1, 16'h0004, 16'h0000); // R8 counting
        chk_flags("R8 complete");
        send(5'd1, 16'h0004, 16'h0000); // R8 after completion

        reserve();
        cfg(6, 4, 32'd1); // R7 zero counts: GO ignored
        chk_flags("R7 zero count");

        for (int k = 0; k < 13; k++) reserve();
        reserve(); // R9 busy
        chk_flags("R9 unchanged");

        cfg(5, 4, 32'd1);
        chk_flags("R8 re-arm clears done");
        cfg(5, 4, 32'd3); // R10 release wins
        chk_flags("R10 release");
        reserve(); // R10 freed slot is reused

        repeat (6) @(negedge clk);
        chk("R4 scoreboard drained", 64'(sb.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule